// File: doc/BRIEF.md
# Post-Increment Load Datapath

This block is a single-cycle execution slice for two memory-read instructions: an ordinary word load, and a load that also moves its base pointer forward by one word. Each cycle it accepts one 32-bit I-type instruction word. It reads the base register and adds the sign-extended immediate to form the effective address. It fetches the addressed word from a small internal data memory. On the next rising edge it writes that word to the destination register. For the post-increment form, the same edge also writes the base value plus four back to the base register.

The register file has two independent write ports. The first port carries loaded data to the destination index. The second port carries the incremented base to the source index and has its own enable, which is raised only by the post-increment form. Within the cycle, the memory is always addressed with the base value before the increment. The slice also holds the program counter, which moves by four on every clock. Stores, branches and other arithmetic operations are not executed here. The data memory holds a fixed pattern that is computed from each word's index.

Top module: `postinc_load_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `pc_o` reads 0. After reset every register x1..x31 holds 0.
- R2: `pc_o` rises by exactly 4 on every rising clock edge while `rst_n` is high.
- R3: Opcode bits [6:0] = 7'b0000011 with funct3 bits [14:12] = 3'b010 is a plain load (`rd_we_o`=1, `inc_we_o`=0). The same opcode with funct3 = 3'b011 is the post-increment load (both enables 1). Any other opcode or funct3 drives both enables low and changes no register.
- R4: `eff_addr_o` equals the register named by bits [19:15] plus the sign-extended 12-bit immediate in bits [31:20].
- R5: `load_data_o` is the memory word at index `eff_addr_o[7:2]` (default depth 64). Address bits [1:0] are ignored, and higher bits wrap. Word i contains the byte i replicated four times, XOR 32'hC0DE0000.
- R6: For either load, the loaded word is written at the next rising edge to the register named by bits [11:7].
- R7: The post-increment load writes the base value plus 4 to the register named by bits [19:15] on that same edge. The memory read uses the base value before the increment.
- R8: When a post-increment load has the same destination and base index, the register receives the loaded word, and the incremented value is dropped.
- R9: Writes to x0 on either port are discarded, and x0 always reads as 0.
- R10: Register reads are combinational. An instruction sees the values written by the previous instruction, and its own writes only on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction executed this cycle |
| pc_o | output | 32 | Program counter |
| eff_addr_o | output | 32 | Effective byte address (base + offset) |
| load_data_o | output | 32 | Word read from the data memory |
| rd_we_o | output | 1 | Destination write enable |
| inc_we_o | output | 1 | Base write-back enable |

## Verification
The clocked assertions assume that `instr_i` is a known value at every rising edge while reset is released, and that reset is held for at least one edge before the first instruction. The stimulus meets these conditions. It changes `instr_i` only on falling edges and holds a defined word in every cycle, including idle cycles (all zeros, an unrecognised opcode). Reset is kept low for several cycles before the first instruction is issued.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int XLEN = 32;
  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [2:0] F3_WORD = 3'b010;
  localparam logic [2:0] F3_WORD_INC = 3'b011;

  typedef struct packed {
    logic dst_we;
    logic inc_we;
  } wr_ctrl_t;

  function automatic logic [XLEN-1:0] sext12(input logic [11:0] v);
    return {{(XLEN-12){v[11]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] step_word(input logic [XLEN-1:0] a);
    return a + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] fill_word(input logic [7:0] idx);
    return {idx, idx, idx, idx} ^ 32'hC0DE0000;
  endfunction
endpackage

// File: rtl/pil_decode.sv
module pil_decode
  import pil_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic [31:0]     instr,
  output logic [RAW-1:0]  base_idx,
  output logic [RAW-1:0]  dst_idx,
  output logic [XLEN-1:0] offset,
  output wr_ctrl_t        ctrl
);
  logic is_load_op;
  assign is_load_op = (instr[6:0] == OPC_LOAD);
  assign base_idx   = instr[15 +: RAW];
  assign dst_idx    = instr[7 +: RAW];
  assign offset     = sext12(instr[31:20]);

  always_comb begin
    ctrl = '0;
    if (is_load_op) begin
      unique case (instr[14:12])
        F3_WORD:     ctrl = '{dst_we: 1'b1, inc_we: 1'b0};
        F3_WORD_INC: ctrl = '{dst_we: 1'b1, inc_we: 1'b1};
        default:     ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/pil_dmem.sv
module pil_dmem
  import pil_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] rdata
);
  localparam int IW = $clog2(DEPTH);
  logic [XLEN-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = fill_word(8'(g));
  end

  logic [IW-1:0] word_idx;
  assign word_idx = addr[IW+1:2];
  assign rdata    = words[word_idx];
endmodule

// File: rtl/pil_regfile.sv
module pil_regfile
  import pil_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  ra,
  output logic [XLEN-1:0] rd_a,
  input  logic            we0,
  input  logic [RAW-1:0]  wa0,
  input  logic [XLEN-1:0] wd0,
  input  logic            we1,
  input  logic [RAW-1:0]  wa1,
  input  logic [XLEN-1:0] wd1
);
  logic [XLEN-1:0] file_q [NREG];
  logic port_clash;
  assign port_clash = we0 && we1 && (wa0 == wa1);

  assign file_q[0] = '0;
  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    logic hit0, hit1;
    assign hit0 = we0 && (wa0 == RAW'(g));
    assign hit1 = we1 && (wa1 == RAW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (hit0) q <= wd0;
      else if (hit1) q <= wd1;
    end
    assign file_q[g] = q;
  end

  assign rd_a = file_q[ra];

  assert_dest_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && wa0 != '0) |=> file_q[$past(wa0)] == $past(wd0));
  assert_inc_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we1 && wa1 != '0 && !port_clash) |=> file_q[$past(wa1)] == $past(wd1));
  assert_clash_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_clash && wa0 != '0) |=> file_q[$past(wa0)] == $past(wd0));
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == '0) |-> rd_a == '0);
endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
  import pil_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr_i,
  output logic [31:0] pc_o,
  output logic [31:0] eff_addr_o,
  output logic [31:0] load_data_o,
  output logic        rd_we_o,
  output logic        inc_we_o
);
  localparam int RAW = $clog2(NREG);

  logic [RAW-1:0]  base_idx, dst_idx;
  logic [XLEN-1:0] offset, base_val, inc_val, mem_word;
  wr_ctrl_t        ctrl;
  logic [XLEN-1:0] pc_q;

  pil_decode #(.RAW(RAW)) u_dec (
    .instr(instr_i), .base_idx(base_idx), .dst_idx(dst_idx),
    .offset(offset), .ctrl(ctrl)
  );

  pil_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra(base_idx), .rd_a(base_val),
    .we0(ctrl.dst_we), .wa0(dst_idx), .wd0(mem_word),
    .we1(ctrl.inc_we), .wa1(base_idx), .wd1(inc_val)
  );

  assign eff_addr_o = base_val + offset;
  assign inc_val    = step_word(base_val);

  pil_dmem #(.DEPTH(DEPTH)) u_mem (.addr(eff_addr_o), .rdata(mem_word));

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= step_word(pc_q);
  end

  assign pc_o        = pc_q;
  assign load_data_o = mem_word;
  assign rd_we_o     = ctrl.dst_we;
  assign inc_we_o    = ctrl.inc_we;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_o == $past(pc_o) + 32'd4);
  assert_inc_needs_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_we_o |-> rd_we_o);
  assert_bad_op_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[6:0] != 7'b0000011) |-> (!rd_we_o && !inc_we_o));
  assert_inc_from_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_we_o |-> inc_val == eff_addr_o - sext12(instr_i[31:20]) + 32'd4);
endmodule

// File: tb/test_postinc_load_unit.sv
module test_postinc_load_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc, ea, ld;
  logic rdwe, incwe;

  always #(CLK_PERIOD/2) clk = ~clk;

  postinc_load_unit i_postinc_load_unit (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_o(pc),
    .eff_addr_o(ea), .load_data_o(ld), .rd_we_o(rdwe), .inc_we_o(incwe)
  );

  typedef struct {
    string tag;
    logic [31:0] addr, data, pcv;
    logic we0, we1;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  logic [31:0] mregs [32];
  logic [31:0] model_pc = 0;
  bit done = 0;

  always @(posedge clk) model_pc <= rst_n ? model_pc + 32'd4 : 32'd0;

  function automatic logic [31:0] exp_word(logic [31:0] a);
    int unsigned i = (a >> 2) % DEPTH;
    return (i * 32'h01010101) ^ 32'hC0DE0000;
  endfunction

  function automatic logic [31:0] enc(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [11:0] im = imm[11:0];
    return {im, rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, logic [31:0] w);
    item_t it;
    logic [31:0] base, addr, data;
    logic isld, isinc;
    int rs1 = w[19:15], rd = w[11:7];
    @(negedge clk);
    instr = w;
    isld = (w[6:0] == 7'b0000011) && (w[14:12] == 3'b010 || w[14:12] == 3'b011);
    isinc = isld && (w[14:12] == 3'b011);
    base = (rs1 == 0) ? 32'd0 : mregs[rs1];
    addr = base + 32'($signed(w[31:20]));
    data = exp_word(addr);
    it.tag = tag; it.addr = addr; it.data = data; it.pcv = model_pc;
    it.we0 = isld; it.we1 = isinc;
    sb.push_back(it);
    if (isinc && rs1 != 0) mregs[rs1] = base + 32'd4;
    if (isld && rd != 0) mregs[rd] = data;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk({it.tag, " addr R4"}, ea, it.addr);
        chk({it.tag, " data R5"}, ld, it.data);
        chk({it.tag, " enables R3"}, {30'd0, rdwe, incwe}, {30'd0, it.we0, it.we1});
        chk({it.tag, " pc R2"}, pc, it.pcv);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 32; i++) mregs[i] = 0;
    repeat (3) @(negedge clk);
    chk("reset pc R1", pc, 32'd0);
    chk("reset enables R1", {31'd0, rdwe}, 32'd0);
    rst_n = 1'b1;
    // R1: registers read zero after reset
    issue("R1 reg x5 zero", enc(0, 5, 0, 0, 7'b0010011));
    issue("R1 reg x31 zero", enc(0, 31, 0, 0, 7'b0010011));
    // R6: plain loads from x0 base
    issue("R6 lw x1", enc(8, 0, 2, 1, 7'b0000011));
    issue("R6 lw x2", enc(4, 0, 2, 2, 7'b0000011));
    // R10: next instruction sees x1
    issue("R10 read x1", enc(0, 1, 0, 0, 7'b0010011));
    // R7: post-increment load through x1
    issue("R7 linc x3,0(x1)", enc(0, 1, 3, 3, 7'b0000011));
    issue("R7 R10 see x1+4", enc(0, 1, 2, 4, 7'b0000011));
    issue("R4 negative imm", enc(-4, 1, 2, 5, 7'b0000011));
    issue("R5 misaligned", enc(3, 0, 2, 6, 7'b0000011));
    issue("R5 wrap", enc(12'h7fc, 0, 2, 7, 7'b0000011));
    // R8: destination equals base
    issue("R8 linc x1,0(x1)", enc(16, 1, 3, 1, 7'b0000011));
    issue("R8 read x1", enc(0, 1, 0, 0, 7'b0010011));
    // R9: x0 writes ignored
    issue("R9 lw x0", enc(20, 0, 2, 0, 7'b0000011));
    issue("R9 linc x8,12(x0)", enc(12, 0, 3, 8, 7'b0000011));
    issue("R9 x0 still zero", enc(0, 0, 0, 0, 7'b0010011));
    // R3: unknown funct3 and opcode change nothing
    issue("R3 funct3 000", enc(4, 2, 0, 2, 7'b0000011));
    issue("R3 funct3 111", enc(4, 2, 7, 2, 7'b0000011));
    issue("R3 other opcode", enc(4, 2, 3, 2, 7'b0100011));
    issue("R3 x2 unchanged", enc(0, 2, 0, 0, 7'b0010011));
    for (int i = 0; i < 24; i++) begin
      int f3 = (i % 5 == 4) ? 0 : ((i % 3 == 0) ? 3 : 2);
      issue("R7 mixed", enc(i * 13 - 40, (i * 7) % 8, f3, (i * 3 + 1) % 8, 7'b0000011));
    end
    issue("idle", 32'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule